// File: doc/BRIEF.md
# Per-Pair Equal Dispatch Balancer

This block sits at one input port of a multi-path switch whose middle stage has K parallel planes. Each arriving cell names an output port. For that output, the block keeps one counter per plane. The cell is sent to the plane that has carried the fewest cells for that output so far. Over time each input-output pair spreads its load evenly, and every plane carries close to 1/K of each flow.

The plane choice is combinational within the cycle the cell is presented. The counters change on the clock edge that accepts the cell. Planes can be masked off with an availability vector. If a cell arrives and every plane is masked, the block raises a stall and leaves all state untouched.

The counters are relative. When every counter of one output becomes nonzero, all of them drop by one together. While all planes stay available, the values therefore stay small. When a plane stays masked for a long time, the counters saturate at their maximum instead of wrapping.

Top module: `equal_dispatch`

## Requirements
- R1: While `cell_vld` is low, `sel_vld` and `stall` are both low.
- R2: After reset every counter is zero, so the first cell to any output goes to plane 0 when plane 0 is available.
- R3: With `cell_vld` high and at least one plane available, `sel_plane` is the available plane whose counter for `cell_dst` is lowest. Ties go to the lowest plane index. `sel_vld` is high in the same cycle.
- R4: An accepted cell adds one to the counter of the chosen plane for its own output, at the next rising clock edge. The counters of all other outputs are unchanged.
- R5: When an update leaves all K counters of an output nonzero, all K of them are reduced by one at that same edge.
- R6: A plane whose `plane_avail` bit is 0 is never selected.
- R7: With `cell_vld` high and `plane_avail` all zero, `stall` is high, `sel_vld` is low, and no counter changes.
- R8: While all planes stay available, the number of cells that each pair has sent to any two planes never differs by more than one. Consecutive cells of one output rotate through the planes in index order.
- R9: A counter that is at its maximum (2^CNT_W - 1) stays there when it is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears all counters |
| cell_vld | input | 1 | A cell is presented this cycle |
| cell_dst | input | DST_W | Output port of the presented cell |
| plane_avail | input | NUM_PLANE | Bit p set means plane p may take a cell |
| sel_plane | output | PLANE_W | Chosen plane index, meaningful when `sel_vld` is high |
| sel_vld | output | 1 | The cell is accepted and goes to `sel_plane` |
| stall | output | 1 | The cell cannot be placed; hold it and present it again |

## Verification
A wrong counter value inside the block shows at the ports the next time a cell for that output arrives. That cell goes to the wrong plane, combinationally, in the same cycle it is presented. An update applied to the wrong output stays hidden until that other output is addressed again. This is why the scoreboard interleaves outputs and tracks the selection of every output from reset.

A missing normalisation or a wrapping counter takes longer to show. It needs one plane masked for about 2^CNT_W·(K-1) cells, after which the masked plane returns and is chosen a predictable number of times in a row. A dedicated phase drives that case.

// File: rtl/equal_dispatch_pkg.sv
package equal_dispatch_pkg;

  // Action taken for the cell presented in the current cycle.
  typedef enum logic [1:0] {
    DISP_IDLE = 2'd0,
    DISP_SEND = 2'd1,
    DISP_HOLD = 2'd2
  } disp_act_e;

endpackage

// File: rtl/equal_dispatch_cnt_bank.sv
module equal_dispatch_cnt_bank #(
  parameter int NUM_OUT   = 8,
  parameter int NUM_PLANE = 4,
  parameter int CNT_W     = 3,
  parameter int DST_W     = 3,
  parameter int PLANE_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [DST_W-1:0]                  row_sel,
  output logic [NUM_PLANE-1:0][CNT_W-1:0]   row_cnt,
  input  logic                              upd_en,
  input  logic [PLANE_W-1:0]                upd_plane
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // One row of K counters per output port.
  logic [NUM_OUT-1:0][NUM_PLANE-1:0][CNT_W-1:0] tally_q;
  logic [NUM_PLANE-1:0][CNT_W-1:0]              row_inc;
  logic [NUM_PLANE-1:0][CNT_W-1:0]              row_nxt;
  logic                                         row_full;

  assign row_cnt = tally_q[row_sel];

  // Saturating bump of the chosen plane, then relative rebase of the row.
  always_comb begin
    row_inc = row_cnt;
    if (row_cnt[upd_plane] != CNT_MAX)
      row_inc[upd_plane] = row_cnt[upd_plane] + 1'b1;
    row_full = 1'b1;
    for (int p = 0; p < NUM_PLANE; p++)
      if (row_inc[p] == '0) row_full = 1'b0;
    row_nxt = row_inc;
    if (row_full)
      for (int p = 0; p < NUM_PLANE; p++)
        row_nxt[p] = row_inc[p] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
    end else if (upd_en) begin
      tally_q[row_sel] <= row_nxt;
    end
  end

  // R7
  // no update request leaves every counter of every output untouched
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(tally_q));

  genvar gd, gp;
  generate
    for (gd = 0; gd < NUM_OUT; gd++) begin : g_row
      logic [NUM_PLANE-1:0] nz;
      for (gp = 0; gp < NUM_PLANE; gp++) begin : g_col
        assign nz[gp] = (tally_q[gd][gp] != '0);
      end
      // R5
      // after any edge, at least one counter of each output sits at zero
      rebased_row_chk: assert property (@(posedge clk) disable iff (rst)
        !(&nz));
    end
  endgenerate

endmodule

// File: rtl/equal_dispatch_pick.sv
module equal_dispatch_pick #(
  parameter int NUM_PLANE = 4,
  parameter int CNT_W     = 3,
  parameter int PLANE_W   = 2
) (
  input  logic [NUM_PLANE-1:0][CNT_W-1:0] cnt,
  input  logic [NUM_PLANE-1:0]            avail,
  output logic                            found,
  output logic [PLANE_W-1:0]              idx
);

  logic [CNT_W-1:0] best;

  // Linear scan: a strict less-than keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int p = 0; p < NUM_PLANE; p++) begin
      if (avail[p] && (!found || cnt[p] < best)) begin
        found = 1'b1;
        idx   = PLANE_W'(p);
        best  = cnt[p];
      end
    end
  end

endmodule

// File: rtl/equal_dispatch_ctrl.sv
module equal_dispatch_ctrl
  import equal_dispatch_pkg::*;
(
  input  logic      cell_vld,
  input  logic      any_plane,
  output disp_act_e act
);

  always_comb begin
    if (!cell_vld)      act = DISP_IDLE;
    else if (any_plane) act = DISP_SEND;
    else                act = DISP_HOLD;
  end

endmodule

// File: rtl/equal_dispatch.sv
module equal_dispatch
  import equal_dispatch_pkg::*;
#(
  parameter int NUM_OUT   = 8,
  parameter int NUM_PLANE = 4,
  parameter int CNT_W     = 3,
  parameter int DST_W     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  parameter int PLANE_W   = (NUM_PLANE > 1) ? $clog2(NUM_PLANE) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cell_vld,
  input  logic [DST_W-1:0]     cell_dst,
  input  logic [NUM_PLANE-1:0] plane_avail,
  output logic [PLANE_W-1:0]   sel_plane,
  output logic                 sel_vld,
  output logic                 stall
);

  logic [NUM_PLANE-1:0][CNT_W-1:0] row_cnt;
  logic                            found;
  disp_act_e                       act;

  equal_dispatch_cnt_bank #(
    .NUM_OUT(NUM_OUT), .NUM_PLANE(NUM_PLANE), .CNT_W(CNT_W),
    .DST_W(DST_W), .PLANE_W(PLANE_W)
  ) u_bank (
    .clk(clk), .rst(rst), .row_sel(cell_dst), .row_cnt(row_cnt),
    .upd_en(sel_vld), .upd_plane(sel_plane)
  );

  equal_dispatch_pick #(
    .NUM_PLANE(NUM_PLANE), .CNT_W(CNT_W), .PLANE_W(PLANE_W)
  ) u_pick (
    .cnt(row_cnt), .avail(plane_avail), .found(found), .idx(sel_plane)
  );

  equal_dispatch_ctrl u_ctrl (
    .cell_vld(cell_vld), .any_plane(found), .act(act)
  );

  assign sel_vld = (act == DISP_SEND);
  assign stall   = (act == DISP_HOLD);

  // Independent recheck of the chosen plane against every available one.
  logic min_bad;
  always_comb begin
    min_bad = 1'b0;
    for (int p = 0; p < NUM_PLANE; p++) begin
      if (plane_avail[p] && row_cnt[p] < row_cnt[sel_plane]) min_bad = 1'b1;
      if (plane_avail[p] && row_cnt[p] == row_cnt[sel_plane] &&
          PLANE_W'(p) < sel_plane) min_bad = 1'b1;
    end
  end

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cell_vld |-> (!sel_vld && !stall));

  // R3
  lowest_count_chk: assert property (@(posedge clk) disable iff (rst)
    sel_vld |-> !min_bad);

  // R6
  masked_plane_chk: assert property (@(posedge clk) disable iff (rst)
    sel_vld |-> plane_avail[sel_plane]);

  // R7
  hold_no_plane_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && plane_avail == '0) |-> (stall && !sel_vld));

endmodule

// File: tb/equal_dispatch_tb.sv
module equal_dispatch_tb;

  localparam int CLK_P = 10;
  localparam int NO    = 8;
  localparam int NP    = 4;
  localparam int CW    = 3;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          cell_vld;
  logic [2:0]    cell_dst;
  logic [NP-1:0] plane_avail;
  logic [1:0]    sel_plane;
  logic          sel_vld;
  logic          stall;

  always #(CLK_P/2) clk = ~clk;

  equal_dispatch #(.NUM_OUT(NO), .NUM_PLANE(NP), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_dst(cell_dst),
    .plane_avail(plane_avail), .sel_plane(sel_plane), .sel_vld(sel_vld),
    .stall(stall)
  );

  typedef struct {
    bit    vld;
    bit    hold;
    int    plane;
    int    dst;
    bit    track;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    mcnt [NO][NP];
  int    obs  [NO][NP];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  function automatic int model_pick(int d, logic [NP-1:0] av);
    int b = -1;
    for (int p = 0; p < NP; p++)
      if (av[p] && (b < 0 || mcnt[d][p] < mcnt[d][b])) b = p;
    return b;
  endfunction

  function automatic void model_update(int d, int p);
    bit all_nz = 1;
    if (mcnt[d][p] < CMAX) mcnt[d][p]++;
    for (int q = 0; q < NP; q++) if (mcnt[d][q] == 0) all_nz = 0;
    if (all_nz) for (int q = 0; q < NP; q++) mcnt[d][q]--;
  endfunction

  // Driver: present one cycle of stimulus and push the expected result.
  task automatic drive(bit v, int d, logic [NP-1:0] av, bit trk, string req);
    exp_t e;
    int   b;
    @(negedge clk);
    cell_vld    = v;
    cell_dst    = 3'(d);
    plane_avail = av;
    b = model_pick(d, av);
    e.vld   = v && (b >= 0);
    e.hold  = v && (b < 0);
    e.plane = b;
    e.dst   = d;
    e.track = trk;
    e.req   = req;
    sb_q.push_back(e);
    if (e.vld) model_update(d, b);
  endtask

  // Monitor: pop and compare a quarter period after the driving edge.
  always @(negedge clk) begin
    #(CLK_P/4);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (sel_vld !== e.vld || stall !== e.hold ||
          (e.vld && sel_plane !== 2'(e.plane))) begin
        n_fail++;
        $display("FAIL %s: dst=%0d got vld=%b stall=%b plane=%0d, expected vld=%b stall=%b plane=%0d",
                 e.req, e.dst, sel_vld, stall, sel_plane, e.vld, e.hold, e.plane);
      end
      if (e.track && sel_vld === 1'b1) begin
        int mx, mn;
        obs[e.dst][sel_plane]++;
        mx = obs[e.dst][0];
        mn = obs[e.dst][0];
        for (int p = 1; p < NP; p++) begin
          if (obs[e.dst][p] > mx) mx = obs[e.dst][p];
          if (obs[e.dst][p] < mn) mn = obs[e.dst][p];
        end
        n_chk++;
        if (mx - mn > 1) begin
          n_fail++;
          $display("FAIL R8: dst=%0d spread got %0d, expected <= 1", e.dst, mx - mn);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NO; d++)
      for (int p = 0; p < NP; p++) begin
        mcnt[d][p] = 0;
        obs[d][p]  = 0;
      end
    rst = 1'b1;
    cell_vld = 1'b0;
    cell_dst = '0;
    plane_avail = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: idle cycles right after reset
    drive(0, 0, 4'hF, 0, "R1");
    drive(0, 3, 4'h0, 0, "R1");

    // R2: first cell to every output lands on plane 0
    for (int d = 0; d < NO; d++) drive(1, d, 4'hF, (d != 5 && d != 6), "R2");

    // R8 / R4: rotation on output 2, interleaved with output 7
    for (int i = 0; i < 8; i++) begin
      drive(1, 2, 4'hF, 1, "R8");
      if (i % 3 == 0) drive(1, 7, 4'hF, 1, "R4");
    end

    // R6 / R3: planes 0 and 2 masked on output 5
    for (int i = 0; i < 6; i++) drive(1, 5, 4'b1010, 0, "R6");
    drive(1, 5, 4'b0100, 0, "R6");
    drive(1, 5, 4'hF, 0, "R3");
    drive(1, 5, 4'hF, 0, "R3");

    // R7: nothing available, then the same output continues as before
    drive(1, 4, 4'h0, 0, "R7");
    drive(1, 4, 4'h0, 0, "R7");
    drive(1, 4, 4'hF, 1, "R7");
    drive(1, 4, 4'hF, 1, "R5");
    drive(1, 4, 4'hF, 1, "R5");
    drive(1, 4, 4'hF, 1, "R5");

    // R9: plane 0 masked long enough to saturate the others on output 6
    for (int i = 0; i < 30; i++) drive(1, 6, 4'b1110, 0, "R9");
    for (int i = 0; i < 12; i++) drive(1, 6, 4'hF, 0, "R9");

    // R3 / R4 / R8: random traffic over outputs that stayed fully available
    for (int i = 0; i < 400; i++) begin
      int pick_d;
      case ($urandom % 6)
        0: pick_d = 0;
        1: pick_d = 1;
        2: pick_d = 2;
        3: pick_d = 3;
        4: pick_d = 4;
        default: pick_d = 7;
      endcase
      if ($urandom % 4 == 0) drive(0, pick_d, 4'hF, 0, "R1");
      else drive(1, pick_d, 4'hF, 1, "R4");
    end

    drive(0, 0, 4'hF, 0, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule